// File: doc/BRIEF.md
# ECC Error Status and Counter Register Bank

This block collects error reports from an ECC-protected memory wrapper and presents them to software as registers. The wrapper raises a one-cycle correctable or uncorrectable event pulse together with the byte address of the failing access, the raw stored data word and the raw stored check bits. The bank keeps one sticky flag per error class, cleared by writing ones. An enable mask selects which flags drive the interrupt line.

A saturating counter of correctable errors has a width set by `CNT_W` (1 to 32). Software can load the counter, and a loaded value is cut to the counter width. Capture registers hold the word-aligned address of the first correctable error. For the first uncorrectable error they hold the word-aligned address, the data word and the check bits. A capture stays fixed until software clears the flag that guards it.

Software reaches the bank through a single-cycle request port. The access sequencer has two states. In `ACC_IDLE` no answer is pending. In `ACC_ACK` the answer to the previous request is on `ack`/`rdata`. The transition `IDLE->ACK` and the transition `ACK->ACK` are both taken when `req` is high. The transition `ACK->IDLE` and the transition `IDLE->IDLE` are both taken when `req` is low.

Top module: `ecc_err_regbank`

## Requirements
- R1: Status register (index 0) holds the correctable flag in bit 0 and the uncorrectable flag in bit 1. An event sets its flag, and the flag stays set. Writing 1 to a bit clears that flag. Writing 0 to a bit leaves it unchanged.
- R2: Interrupt enable register (index 1) is read/write in bits 1:0 (bit 0 correctable, bit 1 uncorrectable). Its upper bits read 0, and after writing 0 it reads 0.
- R3: `irq` is high exactly when some status flag is set together with its enable bit.
- R4: The correctable counter (index 2) increases by exactly one per correctable event.
- R5: At its maximum value 2^CNT_W-1, the counter stays at that value on further correctable events.
- R6: A write to the counter loads `wdata` cut to CNT_W bits. Writing all ones reads back 2^CNT_W-1, or 0xFFFFFFFF when CNT_W is 32. A load wins over a correctable event in the same cycle.
- R7: The correctable address capture (index 3) stores the event address with bits 1:0 forced to 0.
- R8: An uncorrectable event stores the aligned address (index 4), the raw data word (index 5) and the raw check bits (index 6, zero-extended).
- R9: A capture register loads only when its flag is clear before the event. It keeps the first event until the flag is cleared.
- R10: If an event and a write-one-to-clear of the same flag fall in one cycle, the flag stays set.
- R11: The request port works as follows. A request accepted at a clock edge is answered with `ack` high during the next cycle. A read returns the value held before that edge. Indices 3 to 6 ignore writes. Index 7 reads 0.
- R12: After reset, every register reads 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Register access request, one cycle |
| we | input | 1 | 1 = write, 0 = read |
| reg_idx | input | 3 | Register index |
| wdata | input | 32 | Write data |
| ack | output | 1 | Answer valid, cycle after request |
| rdata | output | 32 | Read data |
| ce_evt | input | 1 | Correctable error event pulse |
| ue_evt | input | 1 | Uncorrectable error event pulse |
| evt_addr | input | EA_W | Byte address of the failing access |
| evt_data | input | DATA_W | Raw stored data word |
| evt_check | input | CHK_W | Raw stored check bits |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the main instance with CNT_W=3. With that width, the counter reaches its saturation value after seven events, so a run can cross into saturation many times, both in directed steps and in random traffic. A second instance uses CNT_W=32. This covers the full-width case, where an all-ones write must read back 0xFFFFFFFF and the cut to the counter width removes no bits. All other parameters keep their defaults: 32-bit address, 32-bit data and 7 check bits.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;

    localparam int REG_AW    = 3;
    localparam int REG_W     = 32;
    localparam int NUM_REGS  = 2 ** REG_AW;
    localparam int NUM_FLAGS = 2;
    localparam int ALIGN_B   = 2;

    localparam int FLAG_CE = 0;
    localparam int FLAG_UE = 1;

    localparam logic [REG_AW-1:0] IDX_STATUS   = 3'd0;
    localparam logic [REG_AW-1:0] IDX_IRQ_EN   = 3'd1;
    localparam logic [REG_AW-1:0] IDX_CE_CNT   = 3'd2;
    localparam logic [REG_AW-1:0] IDX_CE_ADDR  = 3'd3;
    localparam logic [REG_AW-1:0] IDX_UE_ADDR  = 3'd4;
    localparam logic [REG_AW-1:0] IDX_UE_DATA  = 3'd5;
    localparam logic [REG_AW-1:0] IDX_UE_CHECK = 3'd6;

    typedef enum logic [0:0] {
        ACC_IDLE = 1'b0,
        ACC_ACK  = 1'b1
    } acc_state_t;

endpackage

// File: rtl/ecc_err_status.sv
module ecc_err_status
    import ecc_err_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] evt,
    input  logic [NUM_FLAGS-1:0] clr,
    input  logic                 en_wr,
    input  logic [NUM_FLAGS-1:0] en_val,
    output logic [NUM_FLAGS-1:0] flags,
    output logic [NUM_FLAGS-1:0] en,
    output logic                 irq
);

    logic [NUM_FLAGS-1:0] flag_q;
    logic [NUM_FLAGS-1:0] en_q;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        // Event has priority over a same-cycle clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[g] <= 1'b0;
            end else if (evt[g]) begin
                flag_q[g] <= 1'b1;
            end else if (clr[g]) begin
                flag_q[g] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[g] <= 1'b0;
            end else if (en_wr) begin
                en_q[g] <= en_val[g];
            end
        end
    end

    assign flags = flag_q;
    assign en    = en_q;
    assign irq   = |(flag_q & en_q);

endmodule

// File: rtl/ecc_err_counter.sv
module ecc_err_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             at_max;

    assign at_max = (cnt_q == CNT_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (inc && !at_max) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evt,
    input  logic         held,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    logic [W-1:0] cap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (evt && !held) begin
            cap_q <= din;
        end
    end

    assign q = cap_q;

endmodule

// File: rtl/ecc_err_regbank.sv
module ecc_err_regbank
    import ecc_err_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int EA_W   = 32,
    parameter int DATA_W = 32,
    parameter int CHK_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [REG_AW-1:0] reg_idx,
    input  logic [REG_W-1:0]  wdata,
    output logic              ack,
    output logic [REG_W-1:0]  rdata,
    input  logic              ce_evt,
    input  logic              ue_evt,
    input  logic [EA_W-1:0]   evt_addr,
    input  logic [DATA_W-1:0] evt_data,
    input  logic [CHK_W-1:0]  evt_check,
    output logic              irq
);

    localparam int UE_W = EA_W + DATA_W + CHK_W;

    // ---------------- access sequencer ----------------
    acc_state_t state_q;
    acc_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: state_d = req ? ACC_ACK : ACC_IDLE;
            ACC_ACK:  state_d = req ? ACC_ACK : ACC_IDLE;
            default:  state_d = ACC_IDLE;
        endcase
    end

    always_comb begin
        ack = (state_q == ACC_ACK);
    end

    // ---------------- write decode ----------------
    logic                wr_en;
    logic [NUM_REGS-1:0] wr_sel;

    assign wr_en = req && we;

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            wr_sel[i] = wr_en && (reg_idx == REG_AW'(i));
        end
    end

    // ---------------- status, enable, interrupt ----------------
    logic [NUM_FLAGS-1:0] evt_vec;
    logic [NUM_FLAGS-1:0] clr_vec;
    logic [NUM_FLAGS-1:0] flags_q;
    logic [NUM_FLAGS-1:0] en_q;

    always_comb begin
        evt_vec          = '0;
        evt_vec[FLAG_CE] = ce_evt;
        evt_vec[FLAG_UE] = ue_evt;
        clr_vec          = wr_sel[IDX_STATUS] ? wdata[NUM_FLAGS-1:0] : '0;
    end

    ecc_err_status u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt_vec),
        .clr    (clr_vec),
        .en_wr  (wr_sel[IDX_IRQ_EN]),
        .en_val (wdata[NUM_FLAGS-1:0]),
        .flags  (flags_q),
        .en     (en_q),
        .irq    (irq)
    );

    // ---------------- correctable counter ----------------
    logic [CNT_W-1:0] ce_cnt;

    ecc_err_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (ce_evt),
        .load     (wr_sel[IDX_CE_CNT]),
        .load_val (wdata[CNT_W-1:0]),
        .count    (ce_cnt)
    );

    // ---------------- capture registers ----------------
    logic [EA_W-1:0] aligned_addr;
    logic [EA_W-1:0] ce_addr_q;
    logic [UE_W-1:0] ue_cap_q;
    logic [EA_W-1:0] ue_addr_q;
    logic [DATA_W-1:0] ue_data_q;
    logic [CHK_W-1:0]  ue_chk_q;

    assign aligned_addr = {evt_addr[EA_W-1:ALIGN_B], {ALIGN_B{1'b0}}};

    ecc_err_capture #(.W(EA_W)) u_ce_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (ce_evt),
        .held  (flags_q[FLAG_CE]),
        .din   (aligned_addr),
        .q     (ce_addr_q)
    );

    ecc_err_capture #(.W(UE_W)) u_ue_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (ue_evt),
        .held  (flags_q[FLAG_UE]),
        .din   ({aligned_addr, evt_data, evt_check}),
        .q     (ue_cap_q)
    );

    assign {ue_addr_q, ue_data_q, ue_chk_q} = ue_cap_q;

    // ---------------- read path ----------------
    logic [REG_W-1:0] rd_mux;
    logic [REG_W-1:0] rdata_q;

    always_comb begin
        rd_mux = '0;
        case (reg_idx)
            IDX_STATUS:   rd_mux[NUM_FLAGS-1:0] = flags_q;
            IDX_IRQ_EN:   rd_mux[NUM_FLAGS-1:0] = en_q;
            IDX_CE_CNT:   rd_mux[CNT_W-1:0]     = ce_cnt;
            IDX_CE_ADDR:  rd_mux[EA_W-1:0]      = ce_addr_q;
            IDX_UE_ADDR:  rd_mux[EA_W-1:0]      = ue_addr_q;
            IDX_UE_DATA:  rd_mux[DATA_W-1:0]    = ue_data_q;
            IDX_UE_CHECK: rd_mux[CHK_W-1:0]     = ue_chk_q;
            default:      rd_mux                = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (req && !we) begin
            rdata_q <= rd_mux;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/ecc_err_checker.sv
module ecc_err_checker
    import ecc_err_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int UE_W  = 71
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req,
    input logic                 we,
    input logic [REG_AW-1:0]    reg_idx,
    input logic [REG_W-1:0]     wdata,
    input logic                 ce_evt,
    input logic                 ue_evt,
    input logic                 ack,
    input logic [NUM_FLAGS-1:0] flags,
    input logic [CNT_W-1:0]     cnt,
    input logic [UE_W-1:0]      ue_cap
);

    localparam logic [CNT_W-1:0] CMAX = '1;

    logic cnt_wr;
    logic clr_ce;

    assign cnt_wr = req && we && (reg_idx == IDX_CE_CNT);
    assign clr_ce = req && we && (reg_idx == IDX_STATUS) && wdata[0];

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flags[FLAG_CE] && !clr_ce |=> flags[FLAG_CE]); // R1

    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ce_evt |=> flags[FLAG_CE]); // R10

    AST_UE_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ue_evt |=> flags[FLAG_UE]); // R1

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ce_evt && !cnt_wr && (cnt != CMAX) |=> cnt == $past(cnt) + CNT_W'(1)); // R4

    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CMAX) && !cnt_wr |=> cnt == CMAX); // R5

    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_evt && !cnt_wr |=> $stable(cnt)); // R4

    AST_UE_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        flags[FLAG_UE] |=> $stable(ue_cap)); // R9

    AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> ack); // R11

    AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !ack); // R11

endmodule

bind ecc_err_regbank ecc_err_checker #(
    .CNT_W (CNT_W),
    .UE_W  (EA_W + DATA_W + CHK_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .we      (we),
    .reg_idx (reg_idx),
    .wdata   (wdata),
    .ce_evt  (ce_evt),
    .ue_evt  (ue_evt),
    .ack     (ack),
    .flags   (flags_q),
    .cnt     (ce_cnt),
    .ue_cap  (ue_cap_q)
);

// File: tb/tb_ecc_err_regbank.sv
module tb_ecc_err_regbank;

    localparam int TB_CNT_W = 3;
    localparam logic [31:0] CMASK = (32'd1 << TB_CNT_W) - 32'd1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] wdata = '0;
    logic        ack, irq;
    logic [31:0] rdata;
    logic        ce_evt = 1'b0, ue_evt = 1'b0;
    logic [31:0] evt_addr = '0, evt_data = '0;
    logic [6:0]  evt_check = '0;

    logic        req32 = 1'b0, we32 = 1'b0, ce32 = 1'b0;
    logic [2:0]  idx32 = '0;
    logic [31:0] wd32 = '0;
    logic        ack32, irq32;
    logic [31:0] rd32;

    int n_cmp = 0;
    int n_bad = 0;

    // bench model
    logic [1:0]  m_flags, m_en;
    logic [31:0] m_cnt, m_ce_addr, m_ue_addr, m_ue_data;
    logic [6:0]  m_ue_chk;

    always #2 clk = ~clk;

    ecc_err_regbank #(.CNT_W(TB_CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .reg_idx(reg_idx),
        .wdata(wdata), .ack(ack), .rdata(rdata), .ce_evt(ce_evt),
        .ue_evt(ue_evt), .evt_addr(evt_addr), .evt_data(evt_data),
        .evt_check(evt_check), .irq(irq)
    );

    ecc_err_regbank #(.CNT_W(32)) dut_w32 (
        .clk(clk), .rst_n(rst_n), .req(req32), .we(we32), .reg_idx(idx32),
        .wdata(wd32), .ack(ack32), .rdata(rd32), .ce_evt(ce32),
        .ue_evt(1'b0), .evt_addr(32'h0), .evt_data(32'h0),
        .evt_check(7'h0), .irq(irq32)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] idx);
        case (idx)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R4";
            3'd3: return "R7";
            3'd4, 3'd5, 3'd6: return "R8";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [31:0] model_read(input logic [2:0] idx);
        case (idx)
            3'd0: return {30'd0, m_flags};
            3'd1: return {30'd0, m_en};
            3'd2: return m_cnt;
            3'd3: return m_ce_addr;
            3'd4: return m_ue_addr;
            3'd5: return m_ue_data;
            3'd6: return {25'd0, m_ue_chk};
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_reset();
        m_flags = '0; m_en = '0; m_cnt = '0;
        m_ce_addr = '0; m_ue_addr = '0; m_ue_data = '0; m_ue_chk = '0;
    endtask

    task automatic model_update(input logic r, input logic w, input logic [2:0] idx,
                                input logic [31:0] wd, input logic ce, input logic ue,
                                input logic [31:0] ea, input logic [31:0] ed, input logic [6:0] ec);
        logic wr = r && w;
        logic [1:0] clr = (wr && idx == 3'd0) ? wd[1:0] : 2'b00;
        if (ce && !m_flags[0]) m_ce_addr = {ea[31:2], 2'b00};
        if (ue && !m_flags[1]) begin
            m_ue_addr = {ea[31:2], 2'b00};
            m_ue_data = ed;
            m_ue_chk  = ec;
        end
        m_flags = (m_flags & ~clr) | {ue, ce};
        if (wr && idx == 3'd1) m_en = wd[1:0];
        if (wr && idx == 3'd2) m_cnt = wd & CMASK;
        else if (ce && m_cnt != CMASK) m_cnt = m_cnt + 32'd1;
    endtask

    // one clock of stimulus; called at a falling edge, returns at the next one
    task automatic step(input logic r, input logic w, input logic [2:0] idx,
                        input logic [31:0] wd, input logic ce, input logic ue,
                        input logic [31:0] ea, input logic [31:0] ed, input logic [6:0] ec);
        logic [31:0] exp_rd;
        req = r; we = w; reg_idx = idx; wdata = wd;
        ce_evt = ce; ue_evt = ue; evt_addr = ea; evt_data = ed; evt_check = ec;
        exp_rd = model_read(idx);
        @(posedge clk);
        model_update(r, w, idx, wd, ce, ue, ea, ed, ec);
        @(negedge clk);
        req = 1'b0; we = 1'b0; ce_evt = 1'b0; ue_evt = 1'b0;
        chk("R11 ack", {31'd0, ack}, {31'd0, r});
        if (r && !w) chk(tag_of(idx), rdata, exp_rd);
        chk("R3 irq", {31'd0, irq}, {31'd0, |(m_flags & m_en)});
    endtask

    task automatic rd(input logic [2:0] idx);
        step(1'b1, 1'b0, idx, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 7'h0);
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        step(1'b1, 1'b1, idx, d, 1'b0, 1'b0, 32'h0, 32'h0, 7'h0);
    endtask

    task automatic ev(input logic ce, input logic ue, input logic [31:0] ea,
                      input logic [31:0] ed, input logic [6:0] ec);
        step(1'b0, 1'b0, 3'd0, 32'h0, ce, ue, ea, ed, ec);
    endtask

    task automatic step32(input logic r, input logic w, input logic [2:0] idx,
                          input logic [31:0] wd, input logic ce);
        req32 = r; we32 = w; idx32 = idx; wd32 = wd; ce32 = ce;
        @(posedge clk);
        @(negedge clk);
        req32 = 1'b0; we32 = 1'b0; ce32 = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int seed_d;
        seed_d = $urandom(32'd1234);
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state
        chk("R12 irq", {31'd0, irq}, 32'd0);
        for (int i = 0; i < 8; i++) begin
            step(1'b1, 1'b0, 3'(i), 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 7'h0);
            chk("R12 reset read", rdata, 32'd0);
        end

        // R2: enable register
        wr(3'd1, 32'h0); rd(3'd1);
        wr(3'd1, 32'hFFFF_FFFF); rd(3'd1);
        chk("R2 upper bits", rdata, 32'h3);

        // R6: counter load clip
        wr(3'd2, 32'hFFFF_FFFF); rd(3'd2);
        chk("R6 all ones", rdata, CMASK);
        wr(3'd2, 32'h0); rd(3'd2);

        // R4/R5: count up and saturate; R7/R9: first capture held
        for (int i = 0; i < 10; i++) begin
            ev(1'b1, 1'b0, 32'h1000_0037 + 32'(i * 16), 32'h0, 7'h0);
            rd(3'd2);
            chk("R5 count", rdata, (i + 1 < 7) ? 32'(i + 1) : 32'd7);
        end
        rd(3'd3);
        chk("R7 aligned addr", rdata, 32'h1000_0034);
        rd(3'd0);

        // R3: irq follows flags and enable
        wr(3'd1, 32'h0);
        chk("R3 masked", {31'd0, irq}, 32'd0);
        wr(3'd1, 32'h1);
        chk("R3 enabled", {31'd0, irq}, 32'd1);

        // R10: event and clear in the same cycle
        step(1'b1, 1'b1, 3'd0, 32'h1, 1'b1, 1'b0, 32'h2000_0001, 32'h0, 7'h0);
        rd(3'd0);
        chk("R10 flag held", rdata & 32'h1, 32'h1);
        wr(3'd0, 32'h0); rd(3'd0);
        wr(3'd0, 32'h1); rd(3'd0);
        chk("R1 cleared", rdata, 32'h0);
        ev(1'b1, 1'b0, 32'h3000_00FE, 32'h0, 7'h0);
        rd(3'd3);
        chk("R9 recapture", rdata, 32'h3000_00FC);

        // R6: load beats a same-cycle event
        step(1'b1, 1'b1, 3'd2, 32'h0000_0002, 1'b1, 1'b0, 32'h0, 32'h0, 7'h0);
        rd(3'd2);
        chk("R6 load wins", rdata, 32'h2);

        // R8/R9: uncorrectable capture
        ev(1'b0, 1'b1, 32'hABCD_1233, 32'hDEAD_BEEF, 7'h5A);
        ev(1'b0, 1'b1, 32'h1111_1111, 32'h2222_2222, 7'h11);
        rd(3'd4); chk("R8 ue addr", rdata, 32'hABCD_1230);
        rd(3'd5); chk("R8 ue data", rdata, 32'hDEAD_BEEF);
        rd(3'd6); chk("R9 ue check held", rdata, 32'h0000_005A);

        // R11: read-only and unmapped
        wr(3'd3, 32'h5555_5555); rd(3'd3);
        wr(3'd6, 32'h7F); rd(3'd6);
        wr(3'd7, 32'hFFFF_FFFF); rd(3'd7);

        // random traffic checked against the model
        for (int n = 0; n < 600; n++) begin
            logic [2:0] idx = 3'($urandom_range(0, 7));
            logic r = ($urandom_range(0, 3) != 0);
            logic w = r && ($urandom_range(0, 2) == 0);
            logic [31:0] wd = (idx == 3'd2) ? ($urandom_range(0, 1) ? 32'hFFFF_FFF0 | 32'($urandom_range(0, 15)) : 32'($urandom_range(0, 6))) : $urandom;
            step(r, w, idx, wd, ($urandom_range(0, 2) == 0), ($urandom_range(0, 5) == 0),
                 $urandom, $urandom, 7'($urandom));
        end

        // R6/R5 with a 32-bit counter
        step32(1'b1, 1'b1, 3'd2, 32'hFFFF_FFFF, 1'b0);
        step32(1'b1, 1'b0, 3'd2, 32'h0, 1'b0);
        chk("R6 w32 all ones", rd32, 32'hFFFF_FFFF);
        step32(1'b0, 1'b0, 3'd0, 32'h0, 1'b1);
        step32(1'b1, 1'b0, 3'd2, 32'h0, 1'b0);
        chk("R5 w32 saturate", rd32, 32'hFFFF_FFFF);
        step32(1'b1, 1'b1, 3'd2, 32'h0, 1'b0);
        step32(1'b0, 1'b0, 3'd0, 32'h0, 1'b1);
        step32(1'b1, 1'b0, 3'd2, 32'h0, 1'b0);
        chk("R4 w32 step", rd32, 32'h1);
        chk("R3 w32 irq", {31'd0, irq32}, 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule